// File: doc/BRIEF.md
# Framed Three-Bit 010/110 Detector

This block watches one serial bit stream and cuts it into consecutive, non-overlapping groups of three qualified bits. On the third bit of a group it raises a single-cycle detect pulse if the last two bits of that group were `1` then `0`. The first bit of the group does not matter, so both `010` and `110` count as a match. After every third bit the machine goes back to its start state no matter what it saw. A group's bits are therefore never shared with the next group, unlike in a sliding-window detector.

The machine has four states. `ST_START` waits for the first bit of a group. `ST_FIRST` means one bit has been taken. `ST_X0` means the second bit was 0. `ST_X1` means the second bit was 1. The transitions are named as follows:
- `T_TAKE_FIRST`: ST_START to ST_FIRST on any valid bit.
- `T_SECOND_ZERO`: ST_FIRST to ST_X0 on a valid 0.
- `T_SECOND_ONE`: ST_FIRST to ST_X1 on a valid 1.
- `T_CLOSE_MISS`: ST_X0 to ST_START on any valid bit, or ST_X1 to ST_START on a valid 1.
- `T_CLOSE_HIT`: ST_X1 to ST_START on a valid 0, with the output raised.
- `T_HOLD`: any state to itself when no valid bit is offered.

The output is Mealy: it depends on the current state and the present input. A build parameter can add one register stage to the output, which delays the pulse by one clock. Group alignment is set only by the synchronous reset.

Top module: `frame_det`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `hit` is 0 and the machine is in ST_START.
- R2: With `REG_OUT`=0, `hit` is 1 in the same cycle as the third valid bit of a group whenever that group is 010 or 110. The bits are listed in arrival order, and the first bit is a don't-care.
- R3: The groups 000, 001, 011, 100, 101 and 111 never raise `hit`.
- R4: After every third valid bit the machine returns to ST_START, so groups never overlap. In the stream 0,1,0,1,0,0 only the third bit gives a hit.
- R5: A cycle with `bit_valid`=0 neither advances the machine nor raises `hit`, whatever the value of `bit_in`.
- R6: A synchronous reset in the middle of a group drops the partial group. The next valid bit is then taken as the first bit of a new group.
- R7: With `REG_OUT`=1, `hit` carries the same pulse as with `REG_OUT`=0, one clock later.
- R8: If reset and a group-completing valid 0 in ST_X1 fall in the same cycle, reset wins: `hit` stays 0 and no delayed pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also sets group alignment |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Detect pulse (Mealy, or registered when `REG_OUT`=1) |

## Verification
Reset and the closing bit of a matching group can arrive in the same cycle. The bench provokes this by offering a group's first two bits, `x` then 1, and then raising `rst` together with a valid 0. It checks that the combinational `hit` stays low in that cycle and that the registered variant shows no pulse on the next cycle. It then sends a fresh 0,1,0 and expects the hit on the third bit, which shows that the partial group was dropped and alignment restarted.

// File: rtl/fdet_pkg.sv
package fdet_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_FIRST = 2'd1,
        ST_X0    = 2'd2,
        ST_X1    = 2'd3
    } fdet_state_t;
endpackage

// File: rtl/fdet_next.sv
module fdet_next
    import fdet_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  fdet_state_t state_i,
    input  logic        valid_i,
    input  logic        bit_i,
    output fdet_state_t next_o,
    output logic        hit_o
);
    logic raw_hit;

    // Next state and Mealy output
    always_comb begin
        next_o  = state_i;          // T_HOLD
        raw_hit = 1'b0;
        if (valid_i) begin
            unique case (state_i)
                ST_START: next_o = ST_FIRST;                  // T_TAKE_FIRST
                ST_FIRST: next_o = bit_i ? ST_X1 : ST_X0;     // T_SECOND_*
                ST_X0:    next_o = ST_START;                  // T_CLOSE_MISS
                ST_X1: begin
                    next_o  = ST_START;                       // T_CLOSE_HIT / MISS
                    raw_hit = !bit_i;
                end
                default:  next_o = ST_START;
            endcase
        end
    end

    // Reset overrides a completing bit in the same cycle (R8)
    assign hit_o = raw_hit & !rst_i;

    // R5: a pulse only comes with a qualified bit
    p_hit_needs_valid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> valid_i)
        else $error("hit without valid bit");
endmodule

// File: rtl/fdet_state_reg.sv
module fdet_state_reg
    import fdet_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        valid_i,
    input  fdet_state_t next_i,
    output fdet_state_t state_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) state_o <= ST_START;
        else       state_o <= next_i;
    end

    // R5: no valid bit, no move
    p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(state_o))
        else $error("state moved without valid bit");

    // R4: third bit closes the group
    p_group_close_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && (state_o == ST_X0 || state_o == ST_X1)) |=> state_o == ST_START)
        else $error("group not closed");

    // R4: any valid bit in start opens a group
    p_group_open_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && state_o == ST_START) |=> state_o == ST_FIRST)
        else $error("group not opened");
endmodule

// File: rtl/fdet_out_stage.sv
module fdet_out_stage #(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hit_i,
    output logic hit_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic hit_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) hit_q <= 1'b0;
                else       hit_q <= hit_i;
            end
            assign hit_o = hit_q;

            // R7: registered output trails the Mealy pulse by one clock
            p_delay_one_r7: assert property (@(posedge clk_i) disable iff (rst_i)
                !$past(rst_i) |-> hit_o == $past(hit_i))
                else $error("registered hit misaligned");
        end else begin : g_comb
            assign hit_o = hit_i;
        end
    endgenerate
endmodule

// File: rtl/frame_det.sv
module frame_det
    import fdet_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic hit
);
    fdet_state_t state_q;
    fdet_state_t state_d;
    logic        mealy_hit;

    fdet_state_reg u_state (
        .clk_i   (clk),
        .rst_i   (rst),
        .valid_i (bit_valid),
        .next_i  (state_d),
        .state_o (state_q)
    );

    fdet_next u_next (
        .clk_i   (clk),
        .rst_i   (rst),
        .state_i (state_q),
        .valid_i (bit_valid),
        .bit_i   (bit_in),
        .next_o  (state_d),
        .hit_o   (mealy_hit)
    );

    fdet_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk_i (clk),
        .rst_i (rst),
        .hit_i (mealy_hit),
        .hit_o (hit)
    );
endmodule

// File: tb/frame_det_bench.sv
module frame_det_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic hit_c;
    logic hit_r;
    int   n_chk = 0;
    int   n_bad = 0;
    logic exp_prev = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    frame_det #(.REG_OUT(1'b0)) u_frame_det (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .hit(hit_c));
    frame_det #(.REG_OUT(1'b1)) u_frame_det_reg (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .hit(hit_r));

    // entries {valid, bit, expected combinational hit}
    localparam int NV = 35;
    localparam logic [2:0] VEC [NV] = '{
        3'b100, 3'b110, 3'b101,            // 010 hit   R2
        3'b110, 3'b110, 3'b101,            // 110 hit   R2
        3'b100, 3'b100, 3'b100,            // 000       R3
        3'b110, 3'b100, 3'b100,            // 100       R3
        3'b100, 3'b110, 3'b110,            // 011       R3
        3'b110, 3'b110, 3'b110,            // 111       R3
        3'b110, 3'b100, 3'b110,            // 101       R3
        3'b100, 3'b100, 3'b110,            // 001       R3
        3'b110, 3'b000, 3'b110, 3'b000, 3'b101, // gaps R5
        3'b100, 3'b110, 3'b101, 3'b110, 3'b100, 3'b100 // R4
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic b,
                        input logic exp, input string req);
        @(negedge clk);
        rst = r; bit_valid = v; bit_in = b;
        #1;
        check(hit_c, exp, req);
        check(hit_r, exp_prev, {req, " R7"});
        exp_prev = r ? 1'b0 : exp;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check(hit_c, 1'b0, "R1 comb in reset");
        check(hit_r, 1'b0, "R1 reg in reset");
        // R1: first cycle after reset, closing-like input must not hit
        step(1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1 re-reset");
        for (int i = 0; i < NV; i++)
            step(1'b0, VEC[i][2], VEC[i][1], VEC[i][0], "R2/R3/R4/R5 vector");
        // R5: invalid with bit 0 in ST_X1 repeatedly, then close
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 1'b0, "R5 idle");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R5 close");
        // R8: reset collides with a completing 0 in ST_X1
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8 collision");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8 no delayed pulse");
        // R6: realigned group after reset
        step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6 hit");
        // R6: reset after one bit drops it
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 reset");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R6 second bit 0");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R6 no hit");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7 tail");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule